// File: doc/BRIEF.md
# Stream-to-Buffer Zero Padder

This block moves words from a packet stream (data, valid, ready, last-beat marker, plus one user/sync sideband bit) into a fixed-length destination buffer. Each transfer is set up by a descriptor that carries a word count and a flag saying whether this transfer closes the buffer. A transfer cannot end early. It always emits exactly the requested number of words on its write-data output.

When a packet ends before the requested count is reached, the block fills the rest of the transfer with all-zero words. While it does so, it keeps the stream input stalled. When the count is reached before the packet ends, the remaining beats stay on the stream, stalled, and become the first words of the next transfer. A one-cycle completion pulse marks the acceptance of each transfer's final word.

An elaboration option enables synchronised start. With this option on, the beats that open a transfer are discarded until one arrives with the sideband bit set. With the option off, the sideband is ignored.

Top module: `stream_zero_padder`

## Requirements
- R1: After reset, `desc_ready` is 1, and `s_tready`, `wr_valid` and `xfer_done` are 0.
- R2: A descriptor is accepted only when the block is idle. `desc_ready` stays 0 from acceptance until the final word of that transfer has been taken at the output, so `desc_ready` is never 1 while `wr_valid` is 1.
- R3: Every transfer produces exactly `desc_words` output words (a length of 0 is not allowed). Stream beats appear on `wr_data` in arrival order.
- R4: If a beat with `s_tlast`=1 is taken before the count is reached, every remaining word of the transfer is written with `wr_data` equal to all zeros.
- R5: While zero words are being produced, `s_tready` is 0.
- R6: If the count is reached on the beat that carries `s_tlast`, no zero words are added. The next transfer starts with the next stream beat.
- R7: If the count is reached before `s_tlast`, further beats are not accepted until a new descriptor is taken. Those beats become the leading words of the next transfer.
- R8: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_data` and `wr_last` hold their values in the next cycle.
- R9: `xfer_done` is 1 for exactly the one cycle in which the final word of a transfer, real or zero, is taken (`wr_valid`=1 and `wr_ready`=1).
- R10: `wr_last` is 1 only on the final word of a transfer whose descriptor had `desc_last`=1.
- R11: With `SYNC_START`=0, `s_tuser` has no effect on any output.
- R12: With `SYNC_START`=1, beats offered at the start of each transfer with `s_tuser`=0 are accepted and discarded. The first beat with `s_tuser`=1 becomes word 0 of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted (block idle) |
| desc_words | input | LEN_W | Transfer length in words, non-zero |
| desc_last | input | 1 | This transfer closes the buffer |
| s_tdata | input | DATA_W | Stream data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tlast | input | 1 | Last beat of a packet |
| s_tuser | input | 1 | Sync sideband, used only with SYNC_START=1 |
| wr_data | output | DATA_W | Write data toward the buffer |
| wr_valid | output | 1 | Write word valid |
| wr_ready | input | 1 | Write word taken |
| wr_last | output | 1 | Final word of a buffer |
| xfer_done | output | 1 | One-cycle pulse: transfer complete |

## Verification
Two events can fall on the same beat: reaching the requested count and seeing the end of the packet. The bench provokes this with a four-word packet sent into a four-word transfer, and with a one-word packet sent into a one-word transfer. It expects the final word to raise the completion pulse directly, with no zero word after it. A second collision occurs when a short packet is followed at once by the next packet with its valid already high. The scoreboard requires zeros in the padding slots, and it checks that `s_tready` is low whenever a padding word is taken. An output ready that toggles pseudo-randomly makes padding and the following flush run under back-pressure.

// File: rtl/zp_pkg.sv
package zp_pkg;

   typedef enum logic [2:0] {
      ZP_IDLE   = 3'd0,
      ZP_SYNC   = 3'd1,
      ZP_STREAM = 3'd2,
      ZP_PAD    = 3'd3,
      ZP_FLUSH  = 3'd4
   } zp_state_e;

endpackage

// File: rtl/zp_ctrl.sv
// Transfer sequencer: counts words, chooses stream or zero source, gates the
// stream ready and retires the transfer once its final word leaves the output.
module zp_ctrl
   import zp_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int SYNC_START = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [LEN_W-1:0] desc_words,
   input  logic             desc_last,
   input  logic             s_tvalid,
   output logic             s_tready,
   input  logic             s_tlast,
   input  logic             s_tuser,
   input  logic             out_space,
   input  logic             out_final_taken,
   output logic             ld_en,
   output logic             ld_zero,
   output logic             ld_final,
   output logic             ld_blast
);

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   zp_state_e        state_q, state_d;
   zp_state_e        start_st;
   logic [LEN_W-1:0] left_q, left_d;
   logic             blast_q, blast_d;
   logic             in_phase, beat, take, pad_ld, at_end;

   generate
      if (SYNC_START != 0) begin : g_sync_start
         assign start_st = ZP_SYNC;
      end else begin : g_free_start
         assign start_st = ZP_STREAM;
      end
   endgenerate

   assign in_phase   = (state_q == ZP_STREAM) || (state_q == ZP_SYNC);
   assign s_tready   = in_phase && out_space;
   assign beat       = s_tvalid && s_tready;
   assign take       = beat && ((state_q == ZP_STREAM) || s_tuser);
   assign pad_ld     = (state_q == ZP_PAD) && out_space;
   assign at_end     = (left_q == ONE);
   assign desc_ready = (state_q == ZP_IDLE);

   assign ld_en    = take || pad_ld;
   assign ld_zero  = pad_ld;
   assign ld_final = ld_en && at_end;
   assign ld_blast = ld_final && blast_q;

   always_comb begin
      state_d = state_q;
      left_d  = left_q;
      blast_d = blast_q;
      unique case (state_q)
         ZP_IDLE: begin
            if (desc_valid) begin
               left_d  = desc_words;
               blast_d = desc_last;
               state_d = start_st;
            end
         end
         ZP_SYNC, ZP_STREAM: begin
            if (take) begin
               left_d = left_q - ONE;
               if (at_end)        state_d = ZP_FLUSH;
               else if (s_tlast)  state_d = ZP_PAD;
               else               state_d = ZP_STREAM;
            end
         end
         ZP_PAD: begin
            if (pad_ld) begin
               left_d = left_q - ONE;
               if (at_end) state_d = ZP_FLUSH;
            end
         end
         ZP_FLUSH: begin
            if (out_final_taken) state_d = ZP_IDLE;
         end
         default: state_d = ZP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ZP_IDLE;
         left_q  <= '0;
         blast_q <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         blast_q <= blast_d;
      end
   end

   // R2: once a descriptor is taken the block is busy in the next cycle
   p_busy_after_desc_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_ready) |=> !desc_ready);

   // R3: zero-length descriptors are not allowed
   p_len_nonzero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_ready) |-> (desc_words != '0));

   // R5: an early end of packet is followed by a stalled stream
   p_stall_after_tlast_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && s_tlast && !at_end) |=> !s_tready);

   // R7: after the count is reached the stream stays stalled
   p_stall_after_count_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (take && at_end) |=> !s_tready);

endmodule

// File: rtl/zp_out_reg.sv
// One-word output stage with valid/ready hold; loads either stream data or zeros.
module zp_out_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_zero,
   input  logic              ld_final,
   input  logic              ld_blast,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_space,
   output logic              final_taken,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic              wr_last
);

   logic [DATA_W-1:0] data_q;
   logic              valid_q, final_q, blast_q;

   assign out_space   = !valid_q || wr_ready;
   assign final_taken = valid_q && wr_ready && final_q;
   assign wr_data     = data_q;
   assign wr_valid    = valid_q;
   assign wr_last     = blast_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         final_q <= 1'b0;
         blast_q <= 1'b0;
      end else if (out_space) begin
         valid_q <= ld_en;
         if (ld_en) begin
            data_q  <= ld_zero ? '0 : in_data;
            final_q <= ld_final;
            blast_q <= ld_blast;
         end
      end
   end

   // R8: a stalled word holds its value
   p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !wr_ready) |=> (valid_q && $stable(data_q) && $stable(blast_q)));

   // R9: completion is a single-cycle pulse
   p_done_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      final_taken |=> !final_taken);

   // R10: the buffer-end marker rides only on a final word
   p_last_on_final_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && blast_q) |-> final_q);

endmodule

// File: rtl/stream_zero_padder.sv
module stream_zero_padder #(
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 12,
   parameter int SYNC_START = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [LEN_W-1:0]  desc_words,
   input  logic              desc_last,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   output logic              s_tready,
   input  logic              s_tlast,
   input  logic              s_tuser,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic              wr_last,
   output logic              xfer_done
);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("stream_zero_padder: DATA_W must be at least 8");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len_w
         $error("stream_zero_padder: LEN_W must be in 1..32");
      end
      if (SYNC_START != 0 && SYNC_START != 1) begin : g_bad_sync
         $error("stream_zero_padder: SYNC_START must be 0 or 1");
      end
   endgenerate

   logic out_space, final_taken, ld_en, ld_zero, ld_final, ld_blast;

   zp_ctrl #(
      .LEN_W      (LEN_W),
      .SYNC_START (SYNC_START)
   ) ctrl_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .desc_valid      (desc_valid),
      .desc_ready      (desc_ready),
      .desc_words      (desc_words),
      .desc_last       (desc_last),
      .s_tvalid        (s_tvalid),
      .s_tready        (s_tready),
      .s_tlast         (s_tlast),
      .s_tuser         (s_tuser),
      .out_space       (out_space),
      .out_final_taken (final_taken),
      .ld_en           (ld_en),
      .ld_zero         (ld_zero),
      .ld_final        (ld_final),
      .ld_blast        (ld_blast)
   );

   zp_out_reg #(
      .DATA_W (DATA_W)
   ) out_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_en       (ld_en),
      .ld_zero     (ld_zero),
      .ld_final    (ld_final),
      .ld_blast    (ld_blast),
      .in_data     (s_tdata),
      .out_space   (out_space),
      .final_taken (final_taken),
      .wr_data     (wr_data),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .wr_last     (wr_last)
   );

   assign xfer_done = final_taken;

   // R2: no descriptor is offered a slot while a word is pending
   p_idle_no_word_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !desc_ready);

endmodule

// File: tb/stream_zero_padder_tb_top.sv
module stream_zero_padder_tb_top;

   localparam int DW = 32;
   localparam int LW = 12;

   typedef struct packed {
      logic [DW-1:0] data;
      logic          blast;
      logic          fin;
      logic          pad;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          desc_valid = 0, desc_last = 0, desc_ready;
   logic [LW-1:0] desc_words = '0;
   logic [DW-1:0] s_tdata = '0;
   logic          s_tvalid = 0, s_tlast = 0, s_tuser = 0, s_tready;
   logic [DW-1:0] wr_data;
   logic          wr_valid, wr_last, xfer_done;
   logic          wr_ready = 0;

   logic          y_desc_valid = 0, y_desc_ready;
   logic [DW-1:0] y_s_tdata = '0;
   logic          y_s_tvalid = 0, y_s_tlast = 0, y_s_tuser = 0, y_s_tready;
   logic [DW-1:0] y_wr_data;
   logic          y_wr_valid, y_wr_last, y_done;

   int   checks = 0, errors = 0;
   bit   finished = 0;
   bit   rand_ready = 0;
   logic [15:0] lfsr = 16'hACE1;
   exp_t exp_q[$];
   logic [DW-1:0] y_got[$];
   int   y_last_cnt = 0, y_done_cnt = 0;

   stream_zero_padder #(.DATA_W(DW), .LEN_W(LW), .SYNC_START(0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_words(desc_words), .desc_last(desc_last),
      .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .s_tlast(s_tlast), .s_tuser(s_tuser),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_last(wr_last), .xfer_done(xfer_done));

   stream_zero_padder #(.DATA_W(DW), .LEN_W(LW), .SYNC_START(1)) dut_sync_i (
      .clk(clk), .rst_n(rst_n),
      .desc_valid(y_desc_valid), .desc_ready(y_desc_ready),
      .desc_words(LW'(2)), .desc_last(1'b1),
      .s_tdata(y_s_tdata), .s_tvalid(y_s_tvalid), .s_tready(y_s_tready),
      .s_tlast(y_s_tlast), .s_tuser(y_s_tuser),
      .wr_data(y_wr_data), .wr_valid(y_wr_valid), .wr_ready(1'b1),
      .wr_last(y_wr_last), .xfer_done(y_done));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // output ready: pseudo-random when enabled, driven away from the edges
   always @(posedge clk) begin
      #2;
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready <= rand_ready ? lfsr[0] : 1'b1;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (wr_valid) chk(!desc_ready, "R2 desc_ready while busy", desc_ready, 0);
         if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R3 unexpected word", wr_data, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(wr_data == e.data, e.pad ? "R4 padding word" : "R3 data word",
                   wr_data, e.data);
               chk(wr_last == e.blast, "R10 wr_last", wr_last, e.blast);
               chk(xfer_done == e.fin, "R9 xfer_done", xfer_done, e.fin);
               if (e.pad) chk(!s_tready, "R5 s_tready during padding", s_tready, 0);
            end
         end else begin
            if (xfer_done) chk(0, "R9 done without final take", xfer_done, 0);
         end
         if (y_wr_valid) begin
            y_got.push_back(y_wr_data);
            if (y_wr_last) y_last_cnt++;
         end
         if (y_done) y_done_cnt++;
      end
   end

   task automatic send_desc(input int words, input bit last);
      bit hs;
      @(negedge clk);
      desc_valid = 1; desc_words = LW'(words); desc_last = last;
      do begin hs = desc_ready; @(negedge clk); end while (!hs);
      desc_valid = 0;
   endtask

   task automatic send_pkt(input int n, input logic [DW-1:0] base);
      bit hs;
      for (int i = 0; i < n; i++) begin
         s_tvalid = 1; s_tdata = base + DW'(i); s_tlast = (i == n - 1);
         s_tuser = s_tdata[0]; // R11: toggles, must not matter
         do begin hs = s_tready; @(negedge clk); end while (!hs);
      end
      s_tvalid = 0; s_tlast = 0;
   endtask

   task automatic expect_word(input logic [DW-1:0] d, input bit bl, input bit fn,
                              input bit pd);
      exp_t e;
      e.data = d; e.blast = bl; e.fin = fn; e.pad = pd;
      exp_q.push_back(e);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(desc_ready == 1, "R1 desc_ready", desc_ready, 1);
      chk(s_tready == 0, "R1 s_tready", s_tready, 0);
      chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
      chk(xfer_done == 0, "R1 xfer_done", xfer_done, 0);
      rst_n = 1;
      @(negedge clk);

      // R6: count and end of packet coincide, no padding
      for (int i = 0; i < 4; i++) expect_word(32'h100 + i, 0, i == 3, 0);
      fork
         send_desc(4, 0);
         send_pkt(4, 32'h100);
      join
      drain();

      // R4 R5 R7: short packet padded, then long packet spans two transfers
      rand_ready = 1;
      expect_word(32'h200, 0, 0, 0);
      expect_word(32'h201, 0, 0, 0);
      for (int i = 0; i < 4; i++) expect_word('0, i == 3, i == 3, 1);
      for (int i = 0; i < 3; i++) expect_word(32'h300 + i, 0, i == 2, 0);
      expect_word(32'h303, 0, 0, 0);
      expect_word(32'h304, 1, 1, 0);
      fork
         begin send_desc(6, 1); send_desc(3, 0); send_desc(2, 1); end
         begin send_pkt(2, 32'h200); send_pkt(5, 32'h300); end
      join
      drain();

      // R6: single-word transfer ending with a single-beat packet
      expect_word(32'h401, 1, 1, 0);
      fork
         send_desc(1, 1);
         send_pkt(1, 32'h401);
      join
      drain();

      // R3 R4: one-beat packet into a three-word transfer under back-pressure
      expect_word(32'h503, 0, 0, 0);
      expect_word('0, 0, 0, 1);
      expect_word('0, 0, 1, 1);
      fork
         send_desc(3, 0);
         send_pkt(1, 32'h503);
      join
      drain();
      rand_ready = 0;

      // R12: synchronised start on the second instance
      begin
         logic [DW-1:0] vals[4] = '{32'hA0, 32'hB0, 32'hC0, 32'hD0};
         bit            usr[4]  = '{0, 0, 1, 0};
         bit hs;
         @(negedge clk);
         y_desc_valid = 1;
         do begin hs = y_desc_ready; @(negedge clk); end while (!hs);
         y_desc_valid = 0;
         for (int i = 0; i < 4; i++) begin
            y_s_tvalid = 1; y_s_tdata = vals[i]; y_s_tuser = usr[i];
            y_s_tlast = (i == 3);
            do begin hs = y_s_tready; @(negedge clk); end while (!hs);
         end
         y_s_tvalid = 0; y_s_tlast = 0;
         repeat (5) @(negedge clk);
      end
      chk(y_got.size() == 2, "R12 sync word count", y_got.size(), 2);
      if (y_got.size() == 2) begin
         chk(y_got[0] == 32'hC0, "R12 first word after sync", y_got[0], 32'hC0);
         chk(y_got[1] == 32'hD0, "R12 second word", y_got[1], 32'hD0);
      end
      chk(y_done_cnt == 1, "R12 sync done count", y_done_cnt, 1);
      chk(y_last_cnt == 1, "R10 sync wr_last count", y_last_cnt, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion (pending %0d)",
                  exp_q.size());
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule